// File: doc/BRIEF.md
# Bidirectional Dual Signature Compactor

This block compacts the parallel response of a circuit under self-test into two multiple-input signature registers. On each clock with capture enabled, the same data word is folded into both registers. The two registers reduce their contents by the same characteristic polynomial, but they shift in opposite directions. The forward register multiplies its state polynomial by x. The reverse register multiplies its state polynomial by x^-1.

A pair of errors can cancel in one register when both errors share the same value of bit index plus remaining shift count. Such a pair cannot cancel in the other register unless both errors fall on the same bit in the same cycle. For this reason every single-bit and double-bit error is exposed. A parameter widens both registers by one stage and multiplies the polynomial by (x+1). In that variant, any odd number of error bits is also exposed, and this covers every triple error.

A session runs in three steps. First, a seed load (or reset) clears both registers. Next, the response words are captured. Finally a done strobe compares both signatures with their golden values and latches the verdict.

Top module: `dual_signature_compactor`

## Requirements
- R1: With capture high, the forward register's next value is (S·x mod P) XOR D. S is the current state taken as a polynomial, with stage j holding the coefficient of x^j. D is the data word, with input bit i added into stage i. In other words, the register shifts toward the MSB, and when the old top stage is 1 the low bits of P are XORed in.
- R2: With capture high, the reverse register's next value is (S·x^-1 mod P) XOR D, with D placed the same way as in R1. In other words, when stage 0 is 1, P is XORed into the state, and the state then shifts one place toward the LSB.
- R3: With reset or seed load high at a clock edge, both registers take the seed value (default all zeros) and both flags clear. This has priority over capture and done in the same cycle.
- R4: With capture low, both registers hold, whatever is on the data input.
- R5: A done strobe compares the pre-edge signatures with the expected inputs. Pass goes high when both match. Fail goes high when either one differs. The two flags are never high together.
- R6: The verdict flags hold their value until the next done strobe, reset or seed load.
- R7: Any single flipped data bit in a captured stream produces fail at done.
- R8: Any two flipped bits produce fail at done. This includes a pair that leaves the forward signature equal to its golden value.
- R9: When MODIFIED=1, each register is DATA_W+1 stages wide and uses P·(x+1). Any three flipped bits then produce fail.
- R10: The default configuration is DATA_W=8 with P = x^8+x^4+x^3+x^2+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset; same effect as seed load |
| seedLoad | input | 1 | Load seed into both registers, clear flags |
| capture | input | 1 | Fold dataIn into both registers this cycle |
| done | input | 1 | Compare signatures with expected values and latch verdict |
| dataIn | input | DATA_W | Parallel response word |
| expFwd | input | REG_W | Golden forward signature |
| expRev | input | REG_W | Golden reverse signature |
| fwdSig | output | REG_W | Forward register state |
| revSig | output | REG_W | Reverse register state |
| passFlag | output | 1 | Latched: both signatures matched |
| failFlag | output | 1 | Latched: a signature differed |

## Verification
Both registers are visible at the ports, so a wrong tap, a wrong shift direction or a misplaced data bit shows up one clock after the capture that triggers it. From then on it persists, because the state is never overwritten except by a seed load. A verdict fault, such as comparing only one signature or using post-capture values, shows up on the flags one clock after done. The aliasing double-error stream is the case that exposes a design which judges on the forward signature alone: in that stream the forward signature equals its golden value while fail must still be raised.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef struct packed {
    logic loadSeed;
    logic shiftEn;
    logic judge;
  } dscStrobes_t;

  // Full characteristic polynomial including the x^dataW term.
  // With modified set, the polynomial is multiplied by (x+1).
  function automatic logic [63:0] fullPoly(input int dataW,
                                           input logic [63:0] taps,
                                           input bit modified);
    logic [63:0] p;
    p = taps | (64'd1 << dataW);
    if (modified) p = p ^ (p << 1);
    return p;
  endfunction

endpackage

// File: rtl/dsc_misr.sv
module dsc_misr
  import dsc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W = 8,
  parameter logic [REG_W:0] POLY = '1,
  parameter bit SHIFT_UP = 1'b1,
  parameter logic [REG_W-1:0] SEED = '0
) (
  input  logic              clk,
  input  dscStrobes_t       st,
  input  logic [DATA_W-1:0] dataIn,
  output logic [REG_W-1:0]  sig
);

  logic [REG_W-1:0] dataExt;
  logic [REG_W-1:0] stepped;

  always_comb begin
    dataExt = '0;
    dataExt[DATA_W-1:0] = dataIn;
  end

  generate
    if (SHIFT_UP) begin : g_up
      always_comb begin
        stepped = {sig[REG_W-2:0], 1'b0};
        if (sig[REG_W-1]) stepped = stepped ^ POLY[REG_W-1:0];
      end
    end else begin : g_down
      logic [REG_W:0] folded;
      always_comb begin
        folded = {1'b0, sig};
        if (sig[0]) folded = folded ^ POLY;
        stepped = folded[REG_W:1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (st.loadSeed) sig <= SEED;
    else if (st.shiftEn) sig <= stepped ^ dataExt;
  end

  assert_seed_load_R3: assert property (@(posedge clk)
    st.loadSeed |=> sig == SEED);

  assert_hold_idle_R4: assert property (@(posedge clk)
    (!st.loadSeed && !st.shiftEn) |=> $stable(sig));

  assert_zero_fixed_point_R1: assert property (@(posedge clk)
    (!st.loadSeed && st.shiftEn && sig == '0 && dataIn == '0) |=> sig == '0);

endmodule

// File: rtl/dsc_datapath.sv
module dsc_datapath
  import dsc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_W = 8,
  parameter logic [REG_W:0] POLY = '1,
  parameter logic [REG_W-1:0] SEED = '0
) (
  input  logic              clk,
  input  dscStrobes_t       st,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [REG_W-1:0]  expFwd,
  input  logic [REG_W-1:0]  expRev,
  output logic [REG_W-1:0]  fwdSig,
  output logic [REG_W-1:0]  revSig,
  output logic              bothMatch
);

  dsc_misr #(.DATA_W(DATA_W), .REG_W(REG_W), .POLY(POLY),
             .SHIFT_UP(1'b1), .SEED(SEED)) fwdMisr_i (
    .clk(clk), .st(st), .dataIn(dataIn), .sig(fwdSig));

  dsc_misr #(.DATA_W(DATA_W), .REG_W(REG_W), .POLY(POLY),
             .SHIFT_UP(1'b0), .SEED(SEED)) revMisr_i (
    .clk(clk), .st(st), .dataIn(dataIn), .sig(revSig));

  always_comb bothMatch = (fwdSig == expFwd) && (revSig == expRev);

endmodule

// File: rtl/dsc_control.sv
module dsc_control
  import dsc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        seedLoad,
  input  logic        capture,
  input  logic        done,
  input  logic        bothMatch,
  output dscStrobes_t st,
  output logic        passFlag,
  output logic        failFlag
);

  always_comb begin
    st.loadSeed = rst | seedLoad;
    st.shiftEn  = capture & ~st.loadSeed;
    st.judge    = done & ~st.loadSeed;
  end

  always_ff @(posedge clk) begin
    if (st.loadSeed) begin
      passFlag <= 1'b0;
      failFlag <= 1'b0;
    end else if (st.judge) begin
      passFlag <= bothMatch;
      failFlag <= ~bothMatch;
    end
  end

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(passFlag && failFlag));

  assert_verdict_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !seedLoad) |=> (passFlag == $past(bothMatch)) && (failFlag != $past(bothMatch)));

  assert_verdict_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!done && !seedLoad) |=> $stable(passFlag) && $stable(failFlag));

  assert_clear_on_seed_R3: assert property (@(posedge clk)
    (rst || seedLoad) |=> !passFlag && !failFlag);

endmodule

// File: rtl/dual_signature_compactor.sv
module dual_signature_compactor
  import dsc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] POLY_TAPS = 8'h1D,
  parameter bit MODIFIED = 1'b0,
  localparam int REG_W = DATA_W + (MODIFIED ? 1 : 0)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seedLoad,
  input  logic              capture,
  input  logic              done,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [REG_W-1:0]  expFwd,
  input  logic [REG_W-1:0]  expRev,
  output logic [REG_W-1:0]  fwdSig,
  output logic [REG_W-1:0]  revSig,
  output logic              passFlag,
  output logic              failFlag
);

  localparam logic [63:0] POLY_FULL = fullPoly(DATA_W, 64'(POLY_TAPS), MODIFIED);
  localparam logic [REG_W:0] POLY = POLY_FULL[REG_W:0];
  localparam logic [REG_W-1:0] SEED = '0;

  dscStrobes_t st;
  logic bothMatch;

  dsc_control control_i (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .capture(capture),
    .done(done), .bothMatch(bothMatch), .st(st),
    .passFlag(passFlag), .failFlag(failFlag));

  dsc_datapath #(.DATA_W(DATA_W), .REG_W(REG_W), .POLY(POLY), .SEED(SEED)) datapath_i (
    .clk(clk), .st(st), .dataIn(dataIn), .expFwd(expFwd), .expRev(expRev),
    .fwdSig(fwdSig), .revSig(revSig), .bothMatch(bothMatch));

endmodule

// File: tb/dual_signature_compactor_tb.sv
module dual_signature_compactor_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, seedLoad = 1'b0, capture = 1'b0, done = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] expF0 = '0, expR0 = '0;
  logic [8:0] expF1 = '0, expR1 = '0;
  logic [7:0] fwd0, rev0;
  logic [8:0] fwd1, rev1;
  logic pass0, fail0, pass1, fail1;

  dual_signature_compactor dut_i (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .capture(capture), .done(done),
    .dataIn(dataIn), .expFwd(expF0), .expRev(expR0),
    .fwdSig(fwd0), .revSig(rev0), .passFlag(pass0), .failFlag(fail0));

  dual_signature_compactor #(.MODIFIED(1'b1)) dutMod_i (
    .clk(clk), .rst(rst), .seedLoad(seedLoad), .capture(capture), .done(done),
    .dataIn(dataIn), .expFwd(expF1), .expRev(expR1),
    .fwdSig(fwd1), .revSig(rev1), .passFlag(pass1), .failFlag(fail1));

  int checks = 0, fails = 0;
  string curReq = "R3";

  // Behavioural reference: polynomial arithmetic on integers
  int mF0 = 0, mR0 = 0, mF1 = 0, mR1 = 0;
  bit mP0 = 0, mX0 = 0, mP1 = 0, mX1 = 0;
  localparam int P0 = 'h11D;   // x^8+x^4+x^3+x^2+1
  localparam int P1 = 'h327;   // P0*(x+1)

  function automatic int mulX(int s, int p, int w);
    s = s * 2;
    if (s >= (1 << w)) s = s ^ p;
    return s;
  endfunction

  function automatic int divX(int s, int p);
    if (s % 2 == 1) s = s ^ p;
    return s / 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit r, bit sl, bit cap, bit dn, logic [7:0] d);
    @(negedge clk);
    rst = r; seedLoad = sl; capture = cap; done = dn; dataIn = d;
    @(posedge clk);
    #1;
    if (r || sl) begin
      mF0 = 0; mR0 = 0; mF1 = 0; mR1 = 0;
      mP0 = 0; mX0 = 0; mP1 = 0; mX1 = 0;
    end else begin
      if (dn) begin
        mP0 = (mF0 == int'(expF0)) && (mR0 == int'(expR0)); mX0 = !mP0;
        mP1 = (mF1 == int'(expF1)) && (mR1 == int'(expR1)); mX1 = !mP1;
      end
      if (cap) begin
        mF0 = mulX(mF0, P0, 8) ^ int'(d);
        mR0 = divX(mR0, P0) ^ int'(d);
        mF1 = mulX(mF1, P1, 9) ^ int'(d);
        mR1 = divX(mR1, P1) ^ int'(d);
      end
    end
    chk("R1 R10 fwd", int'(fwd0), mF0);
    chk("R2 R10 rev", int'(rev0), mR0);
    chk("R1 R9 fwd modified", int'(fwd1), mF1);
    chk("R2 R9 rev modified", int'(rev1), mR1);
    chk({curReq, " R5 pass"}, int'(pass0), int'(mP0));
    chk({curReq, " R5 fail"}, int'(fail0), int'(mX0));
    chk({curReq, " R5 pass modified"}, int'(pass1), int'(mP1));
    chk({curReq, " R5 fail modified"}, int'(fail1), int'(mX1));
  endtask

  function automatic logic [7:0] stim(int t);
    return 8'((t * 73 + 29) ^ (t * t));
  endfunction

  // Seed load, then nCap captures; an idle cycle with junk data every 7th.
  // Error k flips bit eb[k] of capture number ec[k] (ec < 0: unused).
  task automatic session(int nCap, int ec0, int eb0, int ec1, int eb1, int ec2, int eb2);
    step(0, 1, 0, 0, 8'h00);
    for (int t = 0; t < nCap; t++) begin
      logic [7:0] d;
      d = stim(t);
      if (t == ec0) d[eb0] = ~d[eb0];
      if (t == ec1) d[eb1] = ~d[eb1];
      if (t == ec2) d[eb2] = ~d[eb2];
      if (t % 7 == 3) step(0, 0, 0, 0, 8'hA5);   // R4: ignored data
      step(0, 0, 1, 0, d);
    end
  endtask

  int gF0, gR0, gF1, gR1;

  task automatic setGolden();
    expF0 = 8'(gF0); expR0 = 8'(gR0); expF1 = 9'(gF1); expR1 = 9'(gR1);
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R3 reset state
    step(1, 0, 0, 0, 8'h00);
    step(1, 0, 1, 1, 8'hFF);
    chk("R3 reset fwd zero", int'(fwd0), 0);

    // Clean session and golden values
    curReq = "R4";
    session(40, -1, 0, -1, 0, -1, 0);
    gF0 = mF0; gR0 = mR0; gF1 = mF1; gR1 = mR1;
    setGolden();
    curReq = "R5";
    step(0, 0, 0, 1, 8'h00);
    chk("R5 clean pass", int'(pass0), 1);
    chk("R5 clean pass modified", int'(pass1), 1);

    // R6 verdict persists
    curReq = "R6";
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 8'h3C);
    chk("R6 pass held", int'(pass0), 1);

    // R5 single-sided golden mismatch
    curReq = "R5";
    expF0 = 8'(gF0 ^ 1); expF1 = 9'(gF1 ^ 1);
    step(0, 0, 0, 1, 8'h00);
    chk("R5 fwd mismatch fail", int'(fail0), 1);
    setGolden();
    expR0 = 8'(gR0 ^ 8'h80); expR1 = 9'(gR1 ^ 9'h100);
    step(0, 0, 0, 1, 8'h00);
    chk("R5 rev mismatch fail", int'(fail0), 1);
    chk("R5 rev mismatch fail modified", int'(fail1), 1);
    setGolden();

    // R3 seed load clears flags
    curReq = "R3";
    step(0, 1, 0, 0, 8'h00);
    chk("R3 seed clears fail", int'(fail0), 0);

    // R7 single errors
    curReq = "R7";
    for (int k = 0; k < 4; k++) begin
      session(40, k * 11 + 2, (k * 3) % 8, -1, 0, -1, 0);
      step(0, 0, 0, 1, 8'h00);
      chk("R7 single error fail", int'(fail0), 1);
      chk("R7 single error fail modified", int'(fail1), 1);
    end

    // R8 double errors, including a pair that aliases in the forward register
    curReq = "R8";
    session(40, 4, 0, 5, 1, -1, 0);
    chk("R8 forward aliases", int'(fwd0), gF0);
    step(0, 0, 0, 1, 8'h00);
    chk("R8 aliasing pair fail", int'(fail0), 1);
    chk("R8 aliasing pair fail modified", int'(fail1), 1);
    session(40, 10, 7, 30, 2, -1, 0);
    step(0, 0, 0, 1, 8'h00);
    chk("R8 double error fail", int'(fail0), 1);
    session(40, 20, 3, 20, 6, -1, 0);
    step(0, 0, 0, 1, 8'h00);
    chk("R8 same-word double fail", int'(fail0), 1);

    // R9 triple errors on the widened variant
    curReq = "R9";
    session(40, 3, 0, 4, 1, 5, 2);
    step(0, 0, 0, 1, 8'h00);
    chk("R9 triple error fail modified", int'(fail1), 1);
    session(40, 1, 7, 17, 0, 33, 4);
    step(0, 0, 0, 1, 8'h00);
    chk("R9 triple error fail modified", int'(fail1), 1);

    // R3 reset beats capture mid-session
    curReq = "R3";
    step(0, 0, 1, 0, 8'h5A);
    step(1, 0, 1, 1, 8'h77);
    chk("R3 reset over capture", int'(rev0), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule